// File: doc/BRIEF.md
# Thermal Voltage Guardband Trim

This block works out how many millivolts may be taken off a core's requested supply voltage when the die runs below its worst-case junction temperature. A cooler die needs less voltage for the same frequency. The block turns the headroom between the die temperature and 100 °C into a reduction. The size of that reduction also grows with how far the present core ratio sits above a floor ratio of 39.

The caller presents the ratio, the single-core boost ratio and the die temperature with a one-cycle sample strobe. One clock later the block returns a registered reduction and a valid strobe. The reduction stays unchanged until the next sample.

A control bit switches the feature on and off, and it comes out of reset switched on. When the user has customized the ratio, the feature is suppressed unless a force-enable input is asserted. The effective on/off state is reported on its own output.

Top module: `tgb_trim`

## Requirements
- R1: When `ratio` is below 40 or above `boost_ratio` (both unsigned), the sampled reduction is 0.
- R2: `temp_c` is an 8-bit two's-complement value in °C. At 100 °C or above, the sampled reduction is 0.
- R3: When `ratio` equals `boost_ratio` (boost ≥ 40), the reduction is floor(3·(100−T)/2) mV. T is clamped to 0..100, so at or below 0 °C the result is 150.
- R4: For 40 ≤ r ≤ boost, the reduction is floor(3·d·(r−39) / (2·(boost−39))) with d = clamp(100−T, 0, 100). A lower ratio never gives a larger result.
- R5: The control bit resets to 1. A cycle with `cfg_we`=1 loads `cfg_wdata` into it, and a 0 disables the feature.
- R6: `en_state` = control bit AND (NOT `ratio_custom` OR `force_en`). When `en_state` is 0 at the sample, the reduction is 0.
- R7: `out_valid` is high exactly in the cycle after `in_valid`, and `trim_mv` updates only then. Without a strobe, `trim_mv` holds its value.
- R8: During and after reset, `trim_mv` is 0, `out_valid` is 0 and `en_state` is 1 while `ratio_custom` is 0.
- R9: `trim_mv` never exceeds 150.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| ratio | input | 8 | Current core ratio |
| boost_ratio | input | 8 | Maximum single-core boost ratio |
| temp_c | input | 8 | Die temperature, signed °C |
| cfg_we | input | 1 | Control bit write enable |
| cfg_wdata | input | 1 | Control bit write value |
| ratio_custom | input | 1 | User has customized the ratio |
| force_en | input | 1 | Keep feature active despite customization |
| en_state | output | 1 | Effective feature state (0 = disabled) |
| out_valid | output | 1 | Reduction valid strobe |
| trim_mv | output | 8 | Voltage reduction in mV |

## Verification
Every internal decision reaches `trim_mv` one clock after its sample strobe, so a fault shows up on that strobe or not at all. A wrong window decision gives a nonzero value where 0 is expected. A wrong margin clamp shows up at the temperature extremes as a value above 150 or a nonzero value when the die is hot. A lost or stuck control bit appears at once on `en_state`, and on the next sample as a wrong zero or nonzero reduction.

// File: rtl/tgb_pkg.sv
package tgb_pkg;

  // Headroom in degrees below the hot limit, clamped to 0..hot.
  function automatic int margin_c(input int t, input int hot);
    int d;
    d = hot - t;
    if (d < 0) d = 0;
    if (d > hot) d = hot;
    return d;
  endfunction

  // Scaled reduction, truncating.
  function automatic int scaled_mv(input int d, input int r, input int flo,
                                   input int bst, input int num, input int den);
    int top_v;
    int bot_v;
    top_v = d * num * (r - flo);
    bot_v = den * (bst - flo);
    if (bot_v <= 0) return 0;
    return top_v / bot_v;
  endfunction

endpackage

// File: rtl/tgb_ctl.sv
module tgb_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_wdata,
  input  logic ratio_custom,
  input  logic force_en,
  output logic feature_on
);
  logic ctl_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_bit <= 1'b1;
    else if (cfg_we) ctl_bit <= cfg_wdata;
  end

  assign feature_on = ctl_bit & (~ratio_custom | force_en);
endmodule

// File: rtl/tgb_calc.sv
module tgb_calc import tgb_pkg::*; #(
  parameter int RATIO_W     = 8,
  parameter int TEMP_W      = 8,
  parameter int OUT_W       = 8,
  parameter int FLOOR_RATIO = 39,
  parameter int TJ_HOT      = 100,
  parameter int SLOPE_NUM   = 3,
  parameter int SLOPE_DEN   = 2
) (
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RATIO_W-1:0] boost_ratio,
  input  logic [TEMP_W-1:0]  temp_c,
  input  logic               feature_on,
  output logic               in_window,
  output logic [OUT_W-1:0]   raw_mv
);
  int r_i;
  int b_i;
  int t_i;
  int d_i;
  int mv_i;

  always_comb begin
    r_i  = int'(ratio);
    b_i  = int'(boost_ratio);
    t_i  = int'($signed(temp_c));
    d_i  = margin_c(t_i, TJ_HOT);
    in_window = (r_i > FLOOR_RATIO) && (r_i <= b_i);
    mv_i = 0;
    if (in_window && feature_on)
      mv_i = scaled_mv(d_i, r_i, FLOOR_RATIO, b_i, SLOPE_NUM, SLOPE_DEN);
    raw_mv = OUT_W'(mv_i);
  end
endmodule

// File: rtl/tgb_trim.sv
module tgb_trim #(
  parameter int RATIO_W     = 8,
  parameter int TEMP_W      = 8,
  parameter int OUT_W       = 8,
  parameter int FLOOR_RATIO = 39,
  parameter int TJ_HOT      = 100,
  parameter int SLOPE_NUM   = 3,
  parameter int SLOPE_DEN   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RATIO_W-1:0] boost_ratio,
  input  logic [TEMP_W-1:0]  temp_c,
  input  logic               cfg_we,
  input  logic               cfg_wdata,
  input  logic               ratio_custom,
  input  logic               force_en,
  output logic               en_state,
  output logic               out_valid,
  output logic [OUT_W-1:0]   trim_mv
);
  logic             feature_on;
  logic             in_window;
  logic [OUT_W-1:0] raw_mv;

  tgb_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ratio_custom(ratio_custom), .force_en(force_en), .feature_on(feature_on)
  );

  tgb_calc #(
    .RATIO_W(RATIO_W), .TEMP_W(TEMP_W), .OUT_W(OUT_W),
    .FLOOR_RATIO(FLOOR_RATIO), .TJ_HOT(TJ_HOT),
    .SLOPE_NUM(SLOPE_NUM), .SLOPE_DEN(SLOPE_DEN)
  ) u_calc (
    .ratio(ratio), .boost_ratio(boost_ratio), .temp_c(temp_c),
    .feature_on(feature_on), .in_window(in_window), .raw_mv(raw_mv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      trim_mv   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) trim_mv <= raw_mv;
    end
  end

  assign en_state = feature_on;
endmodule

// File: rtl/tgb_trim_chk.sv
module tgb_trim_chk #(
  parameter int OUT_W  = 8,
  parameter int TEMP_W = 8,
  parameter int TJ_HOT = 100,
  parameter int MAX_MV = 150
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [TEMP_W-1:0] temp_c,
  input logic              in_window,
  input logic              feature_on,
  input logic              out_valid,
  input logic [OUT_W-1:0]  trim_mv
);
  p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_window) |=> (trim_mv == '0));

  p_hot_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ($signed(temp_c) >= TJ_HOT)) |=> (trim_mv == '0));

  p_off_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !feature_on) |=> (trim_mv == '0));

  p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_novalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(trim_mv)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(trim_mv) <= MAX_MV);
endmodule

bind tgb_trim tgb_trim_chk #(.OUT_W(OUT_W), .TEMP_W(TEMP_W), .TJ_HOT(TJ_HOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .temp_c(temp_c),
  .in_window(in_window), .feature_on(feature_on),
  .out_valid(out_valid), .trim_mv(trim_mv)
);

// File: tb/test_tgb_trim.sv
`timescale 1ns/1ps
module test_tgb_trim;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] ratio = 8'd0;
  logic [7:0] boost_ratio = 8'd50;
  logic [7:0] temp_c = 8'd0;
  logic cfg_we = 1'b0;
  logic cfg_wdata = 1'b0;
  logic ratio_custom = 1'b0;
  logic force_en = 1'b0;
  logic en_state;
  logic out_valid;
  logic [7:0] trim_mv;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tgb_trim i_tgb_trim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ratio(ratio),
    .boost_ratio(boost_ratio), .temp_c(temp_c), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .ratio_custom(ratio_custom), .force_en(force_en),
    .en_state(en_state), .out_valid(out_valid), .trim_mv(trim_mv)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected reduction from the requirement text.
  function automatic int model(input int r, input int b, input int t, input bit on);
    int d;
    if (!on || r < 40 || r > b) return 0;
    d = (t >= 100) ? 0 : (t <= 0) ? 100 : 100 - t;
    return (3 * d * (r - 39)) / (2 * (b - 39));
  endfunction

  task automatic sample(input string req, input int r, input int b, input int t, input bit on);
    int held;
    @(negedge clk);
    ratio = 8'(r); boost_ratio = 8'(b); temp_c = 8'(t); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), 1);
    check(req, int'(trim_mv), model(r, b, t, on));
    held = int'(trim_mv);
    @(negedge clk);
    check("R7 hold", int'(trim_mv), held);
    check("R7 strobe low", int'(out_valid), 0);
  endtask

  task automatic write_ctl(input bit v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 trim", int'(trim_mv), 0);
    check("R8 valid", int'(out_valid), 0);
    check("R8 en_state", int'(en_state), 1);
  endtask

  task automatic t_window;
    sample("R1 below floor", 39, 50, 20, 1'b1);
    sample("R1 above boost", 51, 50, 20, 1'b1);
  endtask

  task automatic t_hot;
    sample("R2 at 100", 50, 50, 100, 1'b1);
    sample("R2 at 120", 50, 50, 120, 1'b1);
  endtask

  task automatic t_top;
    sample("R3 at 0C", 50, 50, 0, 1'b1);
    sample("R3 at -20C", 50, 50, -20, 1'b1);
    sample("R3 at 30C", 50, 50, 30, 1'b1);
    sample("R3 boost47 33C", 47, 47, 33, 1'b1);
  endtask

  task automatic t_scaled;
    sample("R4 r45 0C", 45, 50, 0, 1'b1);
    sample("R4 r40 50C", 40, 50, 50, 1'b1);
    sample("R4 r48 61C", 48, 50, 61, 1'b1);
  endtask

  task automatic t_ctl;
    write_ctl(1'b0);
    check("R5 write 0", int'(en_state), 0);
    sample("R5 disabled", 50, 50, 0, 1'b0);
    write_ctl(1'b1);
    check("R5 write 1", int'(en_state), 1);
    sample("R5 re-enabled", 50, 50, 0, 1'b1);
  endtask

  task automatic t_custom;
    @(negedge clk); ratio_custom = 1'b1;
    @(negedge clk);
    check("R6 custom off", int'(en_state), 0);
    sample("R6 custom zero", 50, 50, 10, 1'b0);
    force_en = 1'b1;
    @(negedge clk);
    check("R6 forced on", int'(en_state), 1);
    sample("R6 forced value", 50, 50, 10, 1'b1);
    ratio_custom = 1'b0; force_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_hot();
    t_top();
    t_scaled();
    t_ctl();
    t_custom();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule